// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit up-counting timer for a peripheral register block. A system clock enable is first passed through an optional fixed divide-by-16 stage and then through an 8-bit programmable prescaler. The prescaler output advances the counter. When the counter equals the programmed reference value on an advance, a sticky reference event flag is raised. The counter can either continue counting or return to zero on that match. An interrupt output follows the flag when the reference interrupt enable is set.

Software reaches five registers over a single-cycle synchronous bus addressed by byte offset. Writes take effect at the clock edge. Reads are combinational from `addr_i`. Capture-pin edge detection, output pin toggling and external clock sources are not part of this block. The capture register is plain storage, and the capture event flag is only ever cleared.

Top module: `ref_timer`

## Requirements
- R1: Mode bit 0 is the enable. While it is 0, the counter holds its value.
- R2: A mode write that takes bit 0 from 1 to 0 clears the reference register to 0. The written mode value is still stored.
- R3: Mode bits [2:1] select the source of the prescaler input:
  - 1 means every cycle with `tick_i` high.
  - 2 means every 16th such cycle.
  - 0 and 3 hold the counter.
- R4: Mode bits [15:8] hold P. The counter advances once every P+1 selected source ticks. With `tick_i` held high after a mode write, the first match of reference value V lands (V+1)(P+1) edges later for source 1, and 16(V+1)(P+1) edges later for source 2.
- R5: When mode bit 3 is 1, a counter advance that matches the reference loads 0. When bit 3 is 0, the counter increments past the reference.
- R6: `irq_o` is a register. It is 1 in the cycle after mode bit 4 and the reference flag were both 1, and 0 otherwise.
- R7: The event register holds the capture flag in bit 0 and the reference flag in bit 1. Writing it clears the flags whose data bits are 1 and leaves the others unchanged. A reference match in the same cycle as a clear keeps the flag set.
- R8: The byte offsets are:
  - 0x00: mode.
  - 0x04: reference.
  - 0x08: capture, which reads back what was written.
  - 0x0C: counter.
  - 0x11: event.
  - Any other offset reads as 0.
- R9: A counter write loads the written value directly.
- R10: Any write to mode or reference zeroes the counter, the prescaler and the divide-by-16 stage.
- R11: A reference value of 0 with restart enabled matches on every counter advance.
- R12: After reset, all registers read 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | System clock enable feeding the prescaler |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Reference interrupt |

## Verification
The hardest situation to reach from the ports is a reference match in the same cycle as a software clear of the flag. The stimulus creates it with reference 0, prescale 0 and restart enabled, so that a match occurs on every cycle. An event-register clear issued then must leave the reference flag set. The long divide-by-16 paths are reached with `tick_i` held high, and the bench counts edges from the mode write until the flag appears.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int PRE_W  = 8;
  localparam int DIV_W  = 4;   // fixed divide by 2**DIV_W
  localparam int EV_W   = 2;

  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_REF  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CAP  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EV   = 8'h11;

  typedef enum logic [1:0] {
    SRC_OFF0 = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_DIV  = 2'd2,
    SRC_OFF3 = 2'd3
  } src_e;

  localparam int MB_EN  = 0;
  localparam int MB_RST = 3;
  localparam int MB_IE  = 4;
  localparam int EV_REF = 1;
endpackage

// File: rtl/ref_timer_prescale.sv
module ref_timer_prescale
  import ref_timer_pkg::*;
#(
  parameter int P_W = PRE_W,
  parameter int D_W = DIV_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  src_e           src_i,
  input  logic [P_W-1:0] pre_i,
  input  logic           restart_i,
  input  logic           tick_i,
  output logic           step_o
);
  logic [D_W-1:0] div_q;
  logic [P_W-1:0] pre_q;
  logic           sel_tick;

  always_comb begin
    sel_tick = 1'b0;
    if (run_i && tick_i) begin
      if (src_i == SRC_SYS)      sel_tick = 1'b1;
      else if (src_i == SRC_DIV) sel_tick = &div_q;
    end
  end

  assign step_o = sel_tick && (pre_q == pre_i) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      if (run_i && tick_i && src_i == SRC_DIV) div_q <= div_q + 1'b1;
      if (sel_tick) pre_q <= (pre_q == pre_i) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ref_timer_counter.sv
module ref_timer_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] ref_i,
  input  logic         wrap_en_i,
  output logic [W-1:0] count_o,
  output logic         match_o
);
  logic [W-1:0] count_q;

  assign match_o = step_i && !load_i && (count_q == ref_i);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (restart_i) count_q <= '0;
    else if (load_i)    count_q <= load_val_i;
    else if (step_i)    count_q <= (match_o && wrap_en_i) ? '0 : count_q + 1'b1;
  end
endmodule

// File: rtl/ref_timer_events.sv
module ref_timer_events #(
  parameter int N = 2,
  parameter int IRQ_BIT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         irq_en_i,
  output logic [N-1:0] ev_o,
  output logic         irq_o
);
  logic [N-1:0] ev_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      // a new event beats a simultaneous clear
      ev_q  <= (clr_we_i ? (ev_q & ~clr_mask_i) : ev_q) | set_i;
      irq_q <= irq_en_i && ev_q[IRQ_BIT];
    end
  end

  assign ev_o  = ev_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ref_timer.sv
module ref_timer
  import ref_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mode_q, ref_q, cap_q, count;
  logic [EV_W-1:0]   ev;
  logic wr, wr_mode, wr_ref, wr_cap, wr_cnt, wr_ev;
  logic restart, run, step, match;
  src_e src;

  assign wr      = req_i && we_i;
  assign wr_mode = wr && addr_i == OFF_MODE;
  assign wr_ref  = wr && addr_i == OFF_REF;
  assign wr_cap  = wr && addr_i == OFF_CAP;
  assign wr_cnt  = wr && addr_i == OFF_CNT;
  assign wr_ev   = wr && addr_i == OFF_EV;
  assign restart = wr_mode || wr_ref;

  assign src = src_e'(mode_q[2:1]);
  assign run = mode_q[MB_EN] && (src == SRC_SYS || src == SRC_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_mode) begin
        mode_q <= wdata_i;
        if (mode_q[MB_EN] && !wdata_i[MB_EN]) ref_q <= '0;
      end
      if (wr_ref) ref_q <= wdata_i;
      if (wr_cap) cap_q <= wdata_i;
    end
  end

  ref_timer_prescale #(.P_W(PRE_W), .D_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i     (run),
    .src_i     (src),
    .pre_i     (mode_q[DATA_W-1 -: PRE_W]),
    .restart_i (restart),
    .tick_i,
    .step_o    (step)
  );

  ref_timer_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i     (step),
    .restart_i  (restart),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i),
    .ref_i      (ref_q),
    .wrap_en_i  (mode_q[MB_RST]),
    .count_o    (count),
    .match_o    (match)
  );

  ref_timer_events #(.N(EV_W), .IRQ_BIT(EV_REF)) u_ev (
    .clk_i, .rst_ni,
    .set_i      ({match, 1'b0}),
    .clr_we_i   (wr_ev),
    .clr_mask_i (wdata_i[EV_W-1:0]),
    .irq_en_i   (mode_q[MB_IE]),
    .ev_o       (ev),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      OFF_MODE: rdata_o = mode_q;
      OFF_REF:  rdata_o = ref_q;
      OFF_CAP:  rdata_o = cap_q;
      OFF_CNT:  rdata_o = count;
      OFF_EV:   rdata_o = {{(DATA_W-EV_W){1'b0}}, ev};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ref_timer_chk.sv
module ref_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] mode_q,
  input logic [15:0] ref_q,
  input logic [15:0] count,
  input logic [1:0]  ev,
  input logic        match,
  input logic        irq_o
);
  logic any_wr;
  assign any_wr = req_i && we_i;

  p_hold_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[0] && !any_wr) |=> $stable(count));

  p_ref_cleared_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wr && addr_i == 8'h00 && mode_q[0] && !wdata_i[0]) |=> (ref_q == '0));

  p_bad_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q[2:1] == 2'd0 || mode_q[2:1] == 2'd3) && !any_wr) |=> $stable(count));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && mode_q[3] && !any_wr) |=> (count == '0));

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[4] && ev[1]) |=> irq_o);

  p_irq_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_q[4] && ev[1]) |=> !irq_o);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> ev[1]);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wr && (addr_i == 8'h00 || addr_i == 8'h04)) |=> (count == '0));
endmodule

bind ref_timer ref_timer_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
  .mode_q, .ref_q, .count, .ev, .match, .irq_o
);

// File: tb/ref_timer_tb.sv
module ref_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ref_timer u_dut (.*);

  // {mode, reference, edges until reference flag}
  localparam logic [47:0] VEC [5] = '{
    {16'h0003, 16'd5, 16'd6},    // src1 P=0
    {16'h0203, 16'd3, 16'd12},   // src1 P=2
    {16'h0005, 16'd1, 16'd32},   // src2 P=0
    {16'h010B, 16'd0, 16'd2},    // src1 P=1 restart ref 0
    {16'h0105, 16'd2, 16'd96}    // src2 P=1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); end
    #1;
  endtask

  initial begin
    logic [15:0] d;
    int n;
    #7 rst_ni = 1'b1;
    #4;
    // R12 reset state
    rd(8'h00, d); chk(d == 0, "R12 mode", d, 0);
    rd(8'h04, d); chk(d == 0, "R12 ref", d, 0);
    rd(8'h0C, d); chk(d == 0, "R12 count", d, 0);
    rd(8'h11, d); chk(d == 0, "R12 event", d, 0);
    chk(irq_o == 0, "R12 irq", irq_o, 0);

    // R4 R11 table walk
    for (int v = 0; v < 5; v++) begin
      wr(8'h00, 16'h0000);
      wr(8'h11, 16'h0003);
      wr(8'h04, VEC[v][31:16]);
      wr(8'h00, VEC[v][47:32]);
      addr_i = 8'h11;
      n = 0;
      for (int k = 0; k < 300; k++) begin
        @(posedge clk_i); #1;
        n++;
        if (rdata_o[1]) break;
      end
      chk(n == int'(VEC[v][15:0]), "R4 R11 match edge", n, VEC[v][15:0]);
    end

    // R2 disable clears ref, stores new mode
    wr(8'h04, 16'h1234);
    wr(8'h00, 16'h0003);
    wr(8'h00, 16'h0A00);
    rd(8'h00, d); chk(d == 16'h0A00, "R2 mode stored", d, 16'h0A00);
    rd(8'h04, d); chk(d == 0, "R2 ref cleared", d, 0);

    // R9 load, R1 hold while disabled
    wr(8'h0C, 16'h55AA);
    edges(5);
    rd(8'h0C, d); chk(d == 16'h55AA, "R9 R1 load and hold", d, 16'h55AA);

    // R3 unsupported sources hold
    wr(8'h04, 16'd100);
    wr(8'h00, 16'h0001);
    edges(20);
    rd(8'h0C, d); chk(d == 0, "R3 src0 holds", d, 0);
    wr(8'h00, 16'h0007);
    edges(20);
    rd(8'h0C, d); chk(d == 0, "R3 src3 holds", d, 0);

    // R10 restart on reference write
    wr(8'h00, 16'h0003);
    edges(10);
    rd(8'h0C, d); chk(d == 10, "R10 running", d, 10);
    wr(8'h04, 16'd100);
    rd(8'h0C, d); chk(d == 0, "R10 restart", d, 0);
    edges(1);
    rd(8'h0C, d); chk(d == 1, "R10 count after restart", d, 1);

    // R5 restart vs. continue
    wr(8'h00, 16'h0000);
    wr(8'h11, 16'h0003);
    wr(8'h04, 16'd3);
    wr(8'h00, 16'h000B);
    edges(4);
    rd(8'h0C, d); chk(d == 0, "R5 wrap to zero", d, 0);
    wr(8'h00, 16'h0000);
    wr(8'h04, 16'd3);
    wr(8'h00, 16'h0003);
    edges(4);
    rd(8'h0C, d); chk(d == 4, "R5 count past ref", d, 4);

    // R6 irq timing, R7 selective clear
    wr(8'h00, 16'h0000);
    wr(8'h11, 16'h0003);
    wr(8'h04, 16'd2);
    wr(8'h00, 16'h0013);
    edges(3);
    rd(8'h11, d); chk(d == 16'h2, "R6 flag at edge 3", d, 2);
    chk(irq_o == 0, "R6 irq not yet", irq_o, 0);
    edges(1);
    chk(irq_o == 1, "R6 irq one later", irq_o, 1);
    wr(8'h11, 16'h0001);
    rd(8'h11, d); chk(d == 16'h2, "R7 other flag kept", d, 2);
    wr(8'h11, 16'h0002);
    rd(8'h11, d); chk(d == 0, "R7 flag cleared", d, 0);
    chk(irq_o == 1, "R6 irq lags clear", irq_o, 1);
    edges(1);
    chk(irq_o == 0, "R6 irq low", irq_o, 0);

    // R7 set beats clear: match every cycle
    wr(8'h00, 16'h0000);
    wr(8'h04, 16'd0);
    wr(8'h00, 16'h000B);
    edges(3);
    wr(8'h11, 16'h0002);
    rd(8'h11, d); chk(d == 16'h2, "R7 set wins over clear", d, 2);

    // R8 capture storage and unmapped offsets
    wr(8'h08, 16'hBEEF);
    rd(8'h08, d); chk(d == 16'hBEEF, "R8 capture", d, 16'hBEEF);
    rd(8'h20, d); chk(d == 0, "R8 unmapped", d, 0);
    rd(8'h10, d); chk(d == 0, "R8 unmapped 0x10", d, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule